// File: doc/BRIEF.md
# Bus-Idle Sleep Controller

This block decides when a battery monitor leaves normal operation for a low-power sleep state. The decision rests only on the single-wire host bus data line. When sleeping is permitted, the block measures how long the line has been held low, using a slow timing tick supplied from outside. After the line has been low without a break for longer than the idle window, the block raises its sleep level. When the line returns high, the block drops sleep at once and emits a one-cycle wake strobe. That strobe drives both the charge-path enable and the discharge-path enable back to 1.

The permission bit is not writable by the host. It is loaded from one bit of a nonvolatile default byte whenever a recall strobe arrives, and it is 0 after reset. Power gating and the nonvolatile storage sit outside this block. The bus line passes through a two-flop synchronizer before the timer sees it. The idle window is set by the parameter `IDLE_TICKS`, the number of ticks in two seconds. Sleep starts on the tick that would take the low time past that count.

Top module: `bus_idle_sleep_ctl`

## Requirements
- R1: With the permission bit at 1, `sleep_o` rises on the (IDLE_TICKS+1)-th tick counted while the synchronized line is low, and not before.
- R2: While asleep, `sleep_o` falls on the third rising clock edge after the bus line input goes high: two edges for the synchronizer and one for the state register.
- R3: With the permission bit at 0, a low line of any length never raises `sleep_o`.
- R4: On a cycle with `recall_i` high, the permission bit takes bit 5 of `recall_data_i`. The other bits of the byte have no effect. With `recall_i` low the bit holds its value. `sleep_en_o` shows the bit.
- R5: Every exit from sleep produces exactly one cycle of `wake_pulse_o` high, in the same cycle that `sleep_o` falls. This strobe sets the charge and discharge enables to 1. No strobe occurs at other times.
- R6: A high level on the synchronized line before the window expires clears the low-time count, so a later low period must again last the full window.
- R7: The low-time count advances only on cycles with `tick_i` high. With no ticks, sleep is never entered.
- R8: If the permission bit becomes 0 while asleep, `sleep_o` falls on the next clock edge with a wake strobe, even when the line is still low.
- R9: After reset, `sleep_o`, `wake_pulse_o` and `sleep_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_line_i | input | 1 | Raw single-wire bus data line, asynchronous |
| tick_i | input | 1 | Timing tick strobe that paces the low-time count |
| recall_i | input | 1 | Recall strobe for the nonvolatile default byte |
| recall_data_i | input | 8 | Default byte presented with the recall strobe; bit 5 is the sleep permission |
| sleep_en_o | output | 1 | Current sleep permission bit, for host reads |
| sleep_o | output | 1 | High while in sleep |
| wake_pulse_o | output | 1 | One-cycle strobe on exit from sleep that re-enables charge and discharge |

## Verification
A low-time count that is off by one shows at the ports as `sleep_o` rising one tick early or one tick late. The bench checks that edge exactly. A count that is not cleared when the line goes high shows as sleep arriving before a full window after the line goes low again. A state register stuck asleep, or a permission bit taken from the wrong bit of the byte, shows within two or three clocks of the triggering input as a missing wake strobe or a wrong `sleep_en_o`.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;

  typedef enum logic {
    ST_ACTIVE = 1'b0,
    ST_ASLEEP = 1'b1
  } sleep_state_e;

  localparam int unsigned RECALL_W = 8;
  localparam int unsigned EN_BIT   = 5;

endpackage

// File: rtl/rst_release.sv
module rst_release #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RESET_VAL;
          else        stage_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RESET_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic tick_i,
  output logic expire_o
);

  localparam int unsigned W = $clog2(LIMIT + 2);
  localparam logic [W-1:0] LIMIT_C = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;
  logic         at_limit;

  assign at_limit = (cnt_q == LIMIT_C);

  always_comb begin
    cnt_en = !arm_i || tick_i;
    cnt_d  = cnt_q;
    if (!arm_i)        cnt_d = '0;
    else if (at_limit) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = arm_i && tick_i && at_limit;

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic line_hi_i,
  input  logic expire_i,
  output logic asleep_o,
  output logic wake_o
);

  sleep_state_e state_q, state_d;
  logic         wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (en_i && expire_i) state_d = ST_ASLEEP;
      end
      ST_ASLEEP: begin
        if (!en_i || line_hi_i) begin
          state_d = ST_ACTIVE;
          wake_d  = 1'b1;
        end
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign asleep_o = (state_q == ST_ASLEEP);
  assign wake_o   = wake_q;

endmodule

// File: rtl/bus_idle_sleep_ctl.sv
module bus_idle_sleep_ctl
  import sleep_ctl_pkg::*;
#(
  parameter int unsigned IDLE_TICKS  = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_line_i,
  input  logic                tick_i,
  input  logic                recall_i,
  input  logic [RECALL_W-1:0] recall_data_i,
  output logic                sleep_en_o,
  output logic                sleep_o,
  output logic                wake_pulse_o
);

  logic rst_n_int;
  logic line_sync;
  logic sleep_en_q, sleep_en_d;
  logic asleep;
  logic arm;
  logic expire;
  logic unused_recall;

  rst_release #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .async_i (bus_line_i),
    .sync_o  (line_sync)
  );

  always_comb begin
    sleep_en_d = sleep_en_q;
    if (recall_i) sleep_en_d = recall_data_i[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) sleep_en_q <= 1'b0;
    else            sleep_en_q <= sleep_en_d;
  end

  assign unused_recall = ^recall_data_i;

  assign arm = sleep_en_q && !asleep && !line_sync;

  idle_timer #(.LIMIT(IDLE_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .arm_i    (arm),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  sleep_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .en_i      (sleep_en_q),
    .line_hi_i (line_sync),
    .expire_i  (expire),
    .asleep_o  (asleep),
    .wake_o    (wake_pulse_o)
  );

  assign sleep_en_o = sleep_en_q;
  assign sleep_o    = asleep;

endmodule

// File: rtl/bus_idle_sleep_ctl_chk.sv
module bus_idle_sleep_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic line_s,
  input logic sleep_en,
  input logic sleep,
  input logic wake_pulse,
  input logic recall_i,
  input logic recall_bit
);

  AST_ENTRY_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> $past(!line_s && sleep_en)) else $error("entry"); // R1

  AST_WAKE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && line_s) |=> !sleep) else $error("wake"); // R2

  AST_NO_SLEEP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_en |=> !sleep) else $error("disabled"); // R3

  AST_RECALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    recall_i |=> (sleep_en == $past(recall_bit))) else $error("recall"); // R4

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !recall_i |=> $stable(sleep_en)) else $error("hold"); // R4

  AST_PULSE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> wake_pulse) else $error("exit pulse"); // R5

  AST_PULSE_ONLY_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $fell(sleep)) else $error("stray pulse"); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse) else $error("pulse width"); // R5

endmodule

bind bus_idle_sleep_ctl bus_idle_sleep_ctl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .line_s     (line_sync),
  .sleep_en   (sleep_en_o),
  .sleep      (sleep_o),
  .wake_pulse (wake_pulse_o),
  .recall_i   (recall_i),
  .recall_bit (recall_data_i[sleep_ctl_pkg::EN_BIT])
);

// File: tb/bus_idle_sleep_ctl_tb_top.sv
`timescale 1ns/1ps
module bus_idle_sleep_ctl_tb_top;

  localparam int unsigned LIM = 5;

  logic       clk;
  logic       rst_n;
  logic       bus_line;
  logic       tick;
  logic       recall;
  logic [7:0] recall_data;
  logic       sleep_en;
  logic       sleep;
  logic       wake;

  int checks;
  int failures;

  bus_idle_sleep_ctl #(.IDLE_TICKS(LIM)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_line_i    (bus_line),
    .tick_i        (tick),
    .recall_i      (recall),
    .recall_data_i (recall_data),
    .sleep_en_o    (sleep_en),
    .sleep_o       (sleep),
    .wake_pulse_o  (wake)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic do_recall(input logic [7:0] data);
    recall      = 1'b1;
    recall_data = data;
    cycles(1);
    recall      = 1'b0;
    recall_data = ~data;
  endtask

  task automatic wake_up();
    bus_line = 1'b1;
    cycles(2);
    check(sleep, 1'b1, "R2 still asleep before sync delay");
    cycles(1);
    check(sleep, 1'b0, "R2 sleep falls on third edge");
    check(wake, 1'b1, "R5 wake strobe on exit");
    cycles(1);
    check(wake, 1'b0, "R5 wake strobe one cycle");
  endtask

  task automatic t_reset();
    check(sleep, 1'b0, "R9 sleep after reset");
    check(wake, 1'b0, "R9 wake after reset");
    check(sleep_en, 1'b0, "R9 permission after reset");
  endtask

  task automatic t_recall();
    do_recall(8'hDF);
    check(sleep_en, 1'b0, "R4 bit5 clear, others set");
    do_recall(8'h20);
    check(sleep_en, 1'b1, "R4 bit5 set");
    recall_data = 8'h00;
    cycles(4);
    check(sleep_en, 1'b1, "R4 holds without recall");
  endtask

  task automatic t_entry();
    bus_line = 1'b0;
    cycles(LIM + 2);
    check(sleep, 1'b0, "R1 no sleep at window end");
    check(wake, 1'b0, "R5 no strobe while active");
    cycles(1);
    check(sleep, 1'b1, "R1 sleep on tick past window");
    check(wake, 1'b0, "R5 no strobe at entry");
    cycles(10);
    check(sleep, 1'b1, "R1 stays asleep while low");
    wake_up();
  endtask

  task automatic t_restart();
    cycles(3);
    bus_line = 1'b0;
    cycles(4);
    bus_line = 1'b1;
    cycles(4);
    check(sleep, 1'b0, "R6 no sleep from short low");
    bus_line = 1'b0;
    cycles(LIM + 2);
    check(sleep, 1'b0, "R6 count restarted");
    cycles(1);
    check(sleep, 1'b1, "R6 full window after restart");
    wake_up();
  endtask

  task automatic t_tick();
    cycles(3);
    tick     = 1'b0;
    bus_line = 1'b0;
    cycles(30);
    check(sleep, 1'b0, "R7 no sleep without ticks");
    tick = 1'b1;
    cycles(LIM);
    check(sleep, 1'b0, "R7 count starts at first tick");
    cycles(1);
    check(sleep, 1'b1, "R7 sleep after ticks resume");
  endtask

  task automatic t_disable_asleep();
    do_recall(8'h00);
    check(sleep_en, 1'b0, "R4 permission cleared");
    check(sleep, 1'b1, "R8 asleep until next edge");
    cycles(1);
    check(sleep, 1'b0, "R8 exit on permission clear");
    check(wake, 1'b1, "R8 strobe on permission clear");
    cycles(1);
    check(wake, 1'b0, "R5 strobe one cycle");
  endtask

  task automatic t_disabled_low();
    cycles(30);
    check(sleep, 1'b0, "R3 no sleep when disabled");
    check(wake, 1'b0, "R3 no strobe when disabled");
    bus_line = 1'b1;
    cycles(3);
  endtask

  initial begin
    checks      = 0;
    failures    = 0;
    rst_n       = 1'b0;
    bus_line    = 1'b1;
    tick        = 1'b1;
    recall      = 1'b0;
    recall_data = 8'h00;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_recall();
    t_entry();
    t_restart();
    t_tick();
    t_disable_asleep();
    t_disabled_low();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule